// File: doc/BRIEF.md
# Two-Wire Delta-Sigma Converter Read Controller

This block is the host side of a serial link to a delta-sigma converter that exposes only two wires. One wire is a serial clock the controller drives. The other is a shared line the converter drives: it falls to announce that a result is ready, and then carries the result bits. The controller watches the shared line while idle. On a falling edge it clocks in one 24-bit result, most significant bit first, and presents it on a parallel bus with a one-cycle valid strobe.

The number of clock pulses that follow the data bits tells the converter what to do next. A 25th pulse makes it release the shared line high. A 25th and a 26th pulse start a self-calibration, after which the line falls again with fresh data. As a fourth choice, the controller can hold the serial clock high after the data bits to put the converter to sleep. A wake request then drives the clock low, and conversion restarts. Repeating sleep and wake around every conversion gives single-conversion operation.

The end-of-read action is chosen through a small command input and applies to every later read. A command that arrives during a read is parked and takes effect once that read, and any trailing pulses, have finished. The shared line is brought into the clock domain through a two-stage synchronizer, and the reset is asynchronous on assertion and synchronous on release.

Top module: `dsadc_rd_ctrl`

## Requirements
- R1: After reset, `sclk` is low and `busy`, `data_valid` and `asleep` are all low.
- R2: A falling edge on `rdy_dout` while idle starts a read. `busy` and `sclk` go high three clock cycles after the line falls: two synchronizer stages plus the sequencer register.
- R3: During a read, the bits of `rdy_dout` are captured at each falling edge of `sclk` for the first 24 pulses, and the first bit captured becomes bit 23 of the result. `data_out` is loaded with the full word and `data_valid` is high for exactly one cycle per read, in the cycle after the 24th falling edge.
- R4: Each `sclk` pulse is high for HALF_CLKS clock cycles and low for HALF_CLKS clock cycles.
- R5: With end mode 0 (stop), a read gives exactly 24 `sclk` pulses, after which `sclk` rests low and `busy` drops.
- R6: With end mode 1 (release), a read gives exactly 25 `sclk` pulses.
- R7: With end mode 2 (calibrate), a read gives exactly 26 complete `sclk` pulses, including the 26th falling edge.
- R8: With end mode 3 (sleep), `sclk` goes high after the low half of the 24th pulse and stays high. `asleep` rises after SLEEP_CLKS cycles of that high level, which is HALF_CLKS + SLEEP_CLKS cycles after `data_valid`, and it remains high with `sclk` high until a wake request.
- R9: A one-cycle `cmd_wake` while asleep drives `sclk` low and clears `asleep` on the next clock edge. The controller then waits for the next falling edge on `rdy_dout`. `cmd_wake` at any other time has no effect.
- R10: A `cmd_valid` that arrives while `busy` is high does not change the read in progress. Its mode is applied to the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Strobe that loads a new end-of-read mode |
| cmd_mode | input | 2 | End mode: 0 stop, 1 release, 2 calibrate, 3 sleep |
| cmd_wake | input | 1 | Wake request while asleep |
| rdy_dout | input | 1 | Shared ready / serial data line from the converter |
| sclk | output | 1 | Serial clock to the converter |
| data_out | output | DATA_BITS | Last captured result |
| data_valid | output | 1 | One-cycle strobe when `data_out` is loaded |
| busy | output | 1 | Read or trailing pulses or sleep entry in progress |
| asleep | output | 1 | Converter held in sleep |

## Verification
The start latency is fixed at three clock edges after the line falls, so the bench drives the fall just after a falling clock edge and expects `busy` at the third falling edge that follows. Pulse widths, pulse counts and the captured word are measured by sampling every falling clock edge against a behavioural converter that shifts its word out on `sclk` rising edges. The sleep timing is checked as exact distances from the `data_valid` sample: HALF_CLKS + SLEEP_CLKS samples to `asleep`, of which SLEEP_CLKS show `sclk` high. The effect of a wake is expected at the very next sample.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    END_STOP    = 2'd0,
    END_RELEASE = 2'd1,
    END_CAL     = 2'd2,
    END_SLEEP   = 2'd3
  } end_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_HIGH  = 3'd1,
    SQ_LOW   = 3'd2,
    SQ_HOLD  = 3'd3,
    SQ_SLEEP = 3'd4
  } seq_state_e;

endpackage

// File: rtl/dsadc_in_sync.sv
module dsadc_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // line idles high, so reset to 1 to avoid a false start
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign dout = sync_q[STAGES-1];
  assign fall = prev_q & ~sync_q[STAGES-1];

  // R2
  fall_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(sync_q[STAGES-1]));

endmodule

// File: rtl/dsadc_cmd_hold.sv
module dsadc_cmd_hold
  import dsadc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_mode,
  input  logic       busy,
  output end_mode_e  mode
);

  end_mode_e mode_q, mode_d;
  end_mode_e pend_q, pend_d;
  logic      pend_v_q, pend_v_d;

  always_comb begin
    mode_d   = mode_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    // parked command takes over once the read is over
    if (!busy && pend_v_q) begin
      mode_d   = pend_q;
      pend_v_d = 1'b0;
    end
    if (cmd_valid) begin
      if (busy) begin
        pend_d   = end_mode_e'(cmd_mode);
        pend_v_d = 1'b1;
      end else begin
        mode_d   = end_mode_e'(cmd_mode);
        pend_v_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= END_STOP;
      pend_q   <= END_STOP;
      pend_v_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end

  assign mode = mode_q;

  // R10
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mode_q == $past(mode_q)));

  // R10
  cmd_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> pend_v_q);

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int DATA_BITS  = 24,
  parameter int HALF_CLKS  = 8,
  parameter int SLEEP_CLKS = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rdy_fall,
  input  logic      wake,
  input  end_mode_e mode,
  output logic      sclk,
  output logic      sample_en,
  output logic      last_bit,
  output logic      busy,
  output logic      asleep
);

  localparam int CNT_MAX = (HALF_CLKS > SLEEP_CLKS) ? HALF_CLKS : SLEEP_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PCNT_W  = $clog2(DATA_BITS + 3);
  localparam logic [CNT_W-1:0]  HALF_END  = CNT_W'(HALF_CLKS - 1);
  localparam logic [CNT_W-1:0]  SLEEP_END = CNT_W'(SLEEP_CLKS - 1);
  localparam logic [PCNT_W-1:0] DATA_CNT  = PCNT_W'(DATA_BITS);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  hcnt_q, hcnt_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PCNT_W-1:0] total;
  logic              sclk_q, sclk_d;

  // trailing pulses per end mode
  always_comb begin
    unique case (mode)
      END_RELEASE: total = DATA_CNT + PCNT_W'(1);
      END_CAL:     total = DATA_CNT + PCNT_W'(2);
      default:     total = DATA_CNT;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    hcnt_d    = hcnt_q;
    pcnt_d    = pcnt_q;
    sample_en = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (rdy_fall) begin
          state_d = SQ_HIGH;
          hcnt_d  = '0;
          pcnt_d  = PCNT_W'(1);
        end
      end
      SQ_HIGH: begin
        if (hcnt_q == HALF_END) begin
          state_d   = SQ_LOW;
          hcnt_d    = '0;
          sample_en = (pcnt_q <= DATA_CNT);
        end else begin
          hcnt_d = hcnt_q + CNT_W'(1);
        end
      end
      SQ_LOW: begin
        if (hcnt_q == HALF_END) begin
          hcnt_d = '0;
          if (pcnt_q == total) begin
            state_d = (mode == END_SLEEP) ? SQ_HOLD : SQ_IDLE;
          end else begin
            state_d = SQ_HIGH;
            pcnt_d  = pcnt_q + PCNT_W'(1);
          end
        end else begin
          hcnt_d = hcnt_q + CNT_W'(1);
        end
      end
      SQ_HOLD: begin
        if (hcnt_q == SLEEP_END) begin
          state_d = SQ_SLEEP;
          hcnt_d  = '0;
        end else begin
          hcnt_d = hcnt_q + CNT_W'(1);
        end
      end
      SQ_SLEEP: begin
        if (wake) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
    sclk_d = (state_d == SQ_HIGH) || (state_d == SQ_HOLD) || (state_d == SQ_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      hcnt_q  <= '0;
      pcnt_q  <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      pcnt_q  <= pcnt_d;
      sclk_q  <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign last_bit = (pcnt_q == DATA_CNT);
  assign busy     = (state_q != SQ_IDLE) && (state_q != SQ_SLEEP);
  assign asleep   = (state_q == SQ_SLEEP);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && rdy_fall) |=> (sclk && busy));

  // R8
  asleep_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> sclk_q);

  // R9
  wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake) |=> (!sclk_q && !asleep && !busy));

  // R5
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PCNT_W'(DATA_BITS + 2));

  // R4
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HIGH || state_q == SQ_LOW) |-> (hcnt_q <= HALF_END));

endmodule

// File: rtl/dsadc_shift.sv
module dsadc_shift #(
  parameter int DATA_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 last_bit,
  input  logic                 din,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 data_valid
);

  logic [DATA_BITS-1:0] shreg_q, shreg_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 valid_q, valid_d;

  always_comb begin
    shreg_d = shreg_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (sample_en) begin
      shreg_d = {shreg_q[DATA_BITS-2:0], din};
      if (last_bit) begin
        data_d  = {shreg_q[DATA_BITS-2:0], din};
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign data_out   = data_q;
  assign data_valid = valid_q;

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (data_q == $past(data_q)));

endmodule

// File: rtl/dsadc_rd_ctrl.sv
module dsadc_rd_ctrl
  import dsadc_pkg::*;
#(
  parameter int DATA_BITS  = 24,
  parameter int HALF_CLKS  = 8,
  parameter int SLEEP_CLKS = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_mode,
  input  logic                 cmd_wake,
  input  logic                 rdy_dout,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 data_valid,
  output logic                 busy,
  output logic                 asleep
);

  logic      rst_meta_q, rst_core_q;
  logic      line_s, line_fall;
  logic      sample_en, last_bit;
  logic      busy_w, asleep_w, sclk_w;
  end_mode_e mode;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  dsadc_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_q),
    .din  (rdy_dout),
    .dout (line_s),
    .fall (line_fall)
  );

  dsadc_cmd_hold u_cmd (
    .clk      (clk),
    .rst_n    (rst_core_q),
    .cmd_valid(cmd_valid),
    .cmd_mode (cmd_mode),
    .busy     (busy_w),
    .mode     (mode)
  );

  dsadc_seq #(
    .DATA_BITS (DATA_BITS),
    .HALF_CLKS (HALF_CLKS),
    .SLEEP_CLKS(SLEEP_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_q),
    .rdy_fall (line_fall),
    .wake     (cmd_wake),
    .mode     (mode),
    .sclk     (sclk_w),
    .sample_en(sample_en),
    .last_bit (last_bit),
    .busy     (busy_w),
    .asleep   (asleep_w)
  );

  dsadc_shift #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_q),
    .sample_en (sample_en),
    .last_bit  (last_bit),
    .din       (line_s),
    .data_out  (data_out),
    .data_valid(data_valid)
  );

  assign sclk   = sclk_w;
  assign busy   = busy_w;
  assign asleep = asleep_w;

  // R3
  valid_in_low_chk: assert property (@(posedge clk) disable iff (!rst_core_q)
    data_valid |-> (!sclk_w && busy_w));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_core_q |-> (!sclk_w && !busy_w && !asleep_w && !data_valid));

endmodule

// File: tb/sim_dsadc_rd_ctrl.sv
module sim_dsadc_rd_ctrl;

  localparam int HALF  = 4;
  localparam int SLEEP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        cmd_wake = 1'b0;
  logic        rdy_dout;
  logic        sclk;
  logic [23:0] data_out;
  logic        data_valid, busy, asleep;

  int total = 0;
  int fails = 0;

  // behavioural converter
  logic [23:0] word_m = 24'h0;
  int          rise_cnt = 0, fall_cnt = 0, rise0 = 0;
  logic        drv_model = 1'b0, task_level = 1'b1;
  int          kk;

  always #5 clk = ~clk;

  always @(posedge sclk) rise_cnt = rise_cnt + 1;
  always @(negedge sclk) fall_cnt = fall_cnt + 1;

  assign kk = rise_cnt - rise0;
  assign rdy_dout = !drv_model ? task_level :
                    (kk == 0)  ? 1'b0 :
                    (kk <= 24) ? word_m[24 - kk] : 1'b1;

  dsadc_rd_ctrl #(.DATA_BITS(24), .HALF_CLKS(HALF), .SLEEP_CLKS(SLEEP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_wake(cmd_wake), .rdy_dout(rdy_dout), .sclk(sclk), .data_out(data_out),
    .data_valid(data_valid), .busy(busy), .asleep(asleep)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cmd_mode  = m;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_read(input logic [23:0] w, input int exp_rises, input bit exp_sleep,
                          input int mid_cmd, input string req,
                          output int first_busy, output int hi_w, output int lo_w);
    int r0, f0, nval, i, vi, hold_hi, to_sleep, phase;
    logic [23:0] got;
    bit done;
    task_level = 1'b1;
    drv_model  = 1'b0;
    repeat (6) @(negedge clk);
    word_m = w;
    rise0  = rise_cnt;
    r0 = rise_cnt;
    f0 = fall_cnt;
    drv_model = 1'b1;
    first_busy = -1; hi_w = 0; lo_w = 0; phase = 0; nval = 0; vi = 0;
    hold_hi = 0; to_sleep = -1; done = 0; i = 0; got = '0;
    while (!done && i < 4000) begin
      @(negedge clk);
      i++;
      if (busy && first_busy < 0) first_busy = i;
      case (phase)
        0: if (sclk) begin phase = 1; hi_w = 1; end
        1: if (sclk) hi_w++; else begin phase = 2; lo_w = 1; end
        2: if (!sclk) lo_w++; else phase = 3;
        default: ;
      endcase
      if (mid_cmd >= 0 && i == 10) begin cmd_mode = mid_cmd[1:0]; cmd_valid = 1'b1; end
      if (mid_cmd >= 0 && i == 11) cmd_valid = 1'b0;
      if (data_valid) begin nval++; got = data_out; vi = i; end
      if (exp_sleep && nval > 0 && i > vi && sclk && !asleep) hold_hi++;
      if (exp_sleep) begin
        if (asleep) begin done = 1; to_sleep = i - vi; end
      end else if (nval > 0 && !busy) begin
        done = 1;
      end
    end
    chk(done, req, "read completed", done, 1);
    if (exp_sleep) begin
      drv_model  = 1'b0;
      task_level = 1'b1;
    end
    repeat (2 * HALF + 4) @(negedge clk);
    // R3 captured word, MSB first
    chk(got == w, "R3", "data_out", got, w);
    chk(nval == 1, "R3", "data_valid strobes", nval, 1);
    chk(rise_cnt - r0 == exp_rises, req, "sclk rising edges", rise_cnt - r0, exp_rises);
    chk(fall_cnt - f0 == (exp_sleep ? exp_rises - 1 : exp_rises), req, "sclk falling edges",
        fall_cnt - f0, exp_sleep ? exp_rises - 1 : exp_rises);
    chk(sclk == exp_sleep, req, "sclk resting level", sclk, exp_sleep);
    if (exp_sleep) begin
      // R8 timing of sleep entry
      chk(to_sleep == HALF + SLEEP, "R8", "valid to asleep", to_sleep, HALF + SLEEP);
      chk(hold_hi == SLEEP, "R8", "sclk high before asleep", hold_hi, SLEEP);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(data_valid == 1'b0, "R1", "data_valid", data_valid, 0);
    chk(asleep == 1'b0, "R1", "asleep", asleep, 0);
  endtask

  task automatic t_start_and_half();
    int fb, hw, lw;
    run_read(24'h5A3C96, 24, 0, -1, "R5", fb, hw, lw);
    chk(fb == 3, "R2", "cycles to busy", fb, 3);
    chk(hw == HALF, "R4", "sclk high width", hw, HALF);
    chk(lw == HALF, "R4", "sclk low width", lw, HALF);
  endtask

  task automatic t_stop_patterns();
    int fb, hw, lw;
    run_read(24'hFFFFFF, 24, 0, -1, "R5", fb, hw, lw);
    run_read(24'h000001, 24, 0, -1, "R5", fb, hw, lw);
    run_read(24'h800000, 24, 0, -1, "R5", fb, hw, lw);
    run_read(24'hA5F00F, 24, 0, -1, "R5", fb, hw, lw);
    chk(busy == 1'b0, "R5", "busy after read", busy, 0);
  endtask

  task automatic t_release();
    int fb, hw, lw;
    set_mode(2'd1);
    run_read(24'h13579B, 25, 0, -1, "R6", fb, hw, lw);
    chk(rdy_dout == 1'b1, "R6", "line released", rdy_dout, 1);
  endtask

  task automatic t_cal();
    int fb, hw, lw;
    set_mode(2'd2);
    run_read(24'h2468AC, 26, 0, -1, "R7", fb, hw, lw);
  endtask

  task automatic t_sleep_wake();
    int fb, hw, lw;
    set_mode(2'd3);
    run_read(24'hC0FFEE, 25, 1, -1, "R8", fb, hw, lw);
    repeat (20) @(negedge clk);
    chk(sclk && asleep, "R8", "still asleep with sclk high", {sclk, asleep}, 2'b11);
    chk(!busy, "R8", "busy while asleep", busy, 0);
    cmd_wake = 1'b1;
    @(negedge clk);
    cmd_wake = 1'b0;
    chk(sclk == 1'b0, "R9", "sclk after wake", sclk, 0);
    chk(asleep == 1'b0, "R9", "asleep after wake", asleep, 0);
    // single-conversion: next result after wake, then sleep again
    run_read(24'h0F0F0F, 25, 1, -1, "R8", fb, hw, lw);
    cmd_wake = 1'b1;
    @(negedge clk);
    cmd_wake = 1'b0;
    chk(!sclk && !asleep, "R9", "second wake", {sclk, asleep}, 0);
    // wake while idle has no effect on sclk or state
    cmd_wake = 1'b1;
    @(negedge clk);
    cmd_wake = 1'b0;
    @(negedge clk);
    chk(!sclk && !busy && !asleep, "R9", "wake while idle", {sclk, busy, asleep}, 0);
  endtask

  task automatic t_held_cmd();
    int fb, hw, lw;
    set_mode(2'd0);
    run_read(24'h6B1D42, 24, 0, 1, "R10", fb, hw, lw);
    run_read(24'h9E2F71, 25, 0, -1, "R10", fb, hw, lw);
    set_mode(2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_and_half();
    t_stop_patterns();
    t_release();
    t_cal();
    t_sleep_wake();
    t_held_cmd();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule